// File: doc/BRIEF.md
# Register-Mapped FIFO Port Controller

This block drives the local side of a buffer that carries data both ways through two FIFOs. On every rising edge of the local clock it looks at a chip select, a read/write line, an enable, an output enable and a 3-bit address. From these it decides whether to capture a bus word, load the output register, hold it, or ignore the port. Captured words go to one of three places: the outbound FIFO, the bypass path toward the far port, or one of four programmable flag-offset registers. Reads load the output register from one of three sources: the inbound FIFO head, the far port's bypass word, or an offset register.

The FIFO storage, the flag generation and the far port sit outside the block. The block presents push and pop strobes, the captured write word, the four offsets, and the output register together with a drive enable for the tri-state pad. A write attempted straight after a cycle in which the block was driving the bus is refused and reported.

Top module: `fifo_port_ctrl`

## Requirements
- R1: After reset `bus_o` is 0, `bus_oe_o` is 0, all four offset fields of `offsets_o` are 8, and no strobe or error is active.
- R2: With `cs_ni` high, `bus_oe_o` is 0, and no write, offset update, strobe or output-register load happens.
- R3: A write edge (`cs_ni`=0, `rw_i`=0, `en_ni`=0) at address 000 captures `bus_i`. In the next cycle `ob_wr_o` is high and `wdata_o` holds the captured word.
- R4: A write edge at address 001 raises `byp_wr_o` in the next cycle, with the captured word on `wdata_o`.
- R5: A write edge at address 1XX stores `bus_i[8:0]` in an offset register. Field k of `offsets_o` (bits 9k+8..9k) is selected by address bits [1:0]: 100 is outbound almost-empty, 101 outbound almost-full, 110 inbound almost-empty and 111 inbound almost-full.
- R6: A read edge (`cs_ni`=0, `rw_i`=1, `en_ni`=0) at address 000 raises `ib_rd_o` during that cycle and loads `ib_rdata_i` into the output register (`bus_o`).
- R7: A read edge at address 001 loads `byp_rdata_i` into `bus_o` and leaves `ib_rd_o` low.
- R8: A read edge at address 1XX loads the selected offset, zero-extended to 18 bits, into `bus_o`.
- R9: With `rw_i`=1 and `en_ni`=1, `bus_o` is unchanged and `ib_rd_o` stays low, whatever the address.
- R10: `bus_oe_o` is high only while `cs_ni`=0, `oe_ni`=0 and `rw_i` was high at the last clock edge. A low `rw_i` sampled at an edge forces `bus_oe_o` low even with `oe_ni`=0.
- R11: A write edge that falls in a cycle where `bus_oe_o` is high is refused. `err_o` pulses in the next cycle, and no capture, strobe or offset change occurs.
- R12: A write edge at address 000 while `ob_full_i` is high produces no `ob_wr_o` strobe.
- R13: A write-direction edge with `en_ni`=1 is ignored and changes no offset.
- R14: Addresses 010 and 011 select nothing. A write there raises no strobe, and a read leaves `bus_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| en_ni | input | 1 | Cycle enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 3 | Resource address |
| bus_i | input | 18 | Word arriving from the data pad |
| bus_o | output | 18 | Output register toward the data pad |
| bus_oe_o | output | 1 | Pad drive enable (0 = high impedance) |
| ob_full_i | input | 1 | Outbound FIFO full |
| ob_wr_o | output | 1 | Outbound FIFO push strobe |
| byp_wr_o | output | 1 | Bypass word valid toward far port |
| wdata_o | output | 18 | Captured input register word |
| ib_rdata_i | input | 18 | Inbound FIFO head word |
| ib_rd_o | output | 1 | Inbound FIFO read-pointer advance |
| byp_rdata_i | input | 18 | Far port's bypass input register |
| offsets_o | output | 36 | Four 9-bit flag offsets, field k at bits 9k+8..9k |
| err_o | output | 1 | Refused write-after-drive pulse |

## Verification
The bound checker watches the timing-level rules on every cycle. A pop is followed by the popped word in the output register. Every push traces back to a legal, non-full write edge. A full FIFO blocks the push. A refused write never coexists with a strobe. A sampled write direction turns the pad off. A deselected or held port keeps its output register still. What only directed scenarios can show is the data content: the exact words reaching the FIFO and bypass queues in order, offset values landing in the right field, the offset readback, and that refused, disabled, enable-high and reserved-address writes leave each offset untouched.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {CMD_IDLE, CMD_WRITE, CMD_READ, CMD_HOLD} cmd_e;
  typedef enum logic [1:0] {AK_FIFO, AK_BYP, AK_OFF, AK_NONE} addr_kind_e;

  function automatic addr_kind_e addr_kind(input logic [2:0] a);
    if (a[2])      return AK_OFF;
    else if (a[1]) return AK_NONE;
    else if (a[0]) return AK_BYP;
    else           return AK_FIFO;
  endfunction
endpackage

// File: rtl/fpc_cmd_decode.sv
module fpc_cmd_decode
  import fpc_pkg::*;
(
  input  logic cs_ni,
  input  logic rw_i,
  input  logic en_ni,
  input  logic bus_drv_i,
  output cmd_e cmd_o,
  output logic wr_err_o
);
  always_comb begin
    cmd_o    = CMD_IDLE;
    wr_err_o = 1'b0;
    if (!cs_ni) begin
      if (rw_i) begin
        cmd_o = en_ni ? CMD_HOLD : CMD_READ;
      end else if (!en_ni) begin
        // write right after a driving cycle is refused
        if (bus_drv_i) wr_err_o = 1'b1;
        else           cmd_o    = CMD_WRITE;
      end
    end
  end
endmodule

// File: rtl/fpc_offset_bank.sv
module fpc_offset_bank #(
  parameter int OFF_W   = 9,
  parameter int NUM     = 4,
  parameter int RST_VAL = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [$clog2(NUM)-1:0] sel_i,
  input  logic [OFF_W-1:0]       wdata_i,
  output logic [NUM*OFF_W-1:0]   off_o,
  output logic [OFF_W-1:0]       rd_o
);
  localparam int SEL_W = $clog2(NUM);

  for (genvar g = 0; g < NUM; g++) begin : g_off
    logic [OFF_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= OFF_W'(RST_VAL);
      else if (wr_en_i && sel_i == SEL_W'(g))        q <= wdata_i;
    end
    assign off_o[g*OFF_W +: OFF_W] = q;
  end

  assign rd_o = off_o[sel_i*OFF_W +: OFF_W];
endmodule

// File: rtl/fpc_out_path.sv
module fpc_out_path
  import fpc_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFF_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  addr_kind_e        kind_i,
  input  logic [DATA_W-1:0] fifo_i,
  input  logic [DATA_W-1:0] byp_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              cs_ni,
  input  logic              oe_ni,
  input  logic              rw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              drive_o
);
  logic              rw_q;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] src;

  always_comb begin
    unique case (kind_i)
      AK_FIFO: src = fifo_i;
      AK_BYP:  src = byp_i;
      AK_OFF:  src = DATA_W'(off_i);
      default: src = out_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rw_q  <= 1'b0;
      out_q <= '0;
    end else begin
      rw_q <= rw_i;
      if (load_i) out_q <= src;
    end
  end

  assign data_o  = out_q;
  assign drive_o = !cs_ni && !oe_ni && rw_q;
endmodule

// File: rtl/fifo_port_ctrl.sv
module fifo_port_ctrl
  import fpc_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int OFF_W   = 9,
  parameter int OFF_RST = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                rw_i,
  input  logic                en_ni,
  input  logic                oe_ni,
  input  logic [2:0]          addr_i,
  input  logic [DATA_W-1:0]   bus_i,
  output logic [DATA_W-1:0]   bus_o,
  output logic                bus_oe_o,
  input  logic                ob_full_i,
  output logic                ob_wr_o,
  output logic                byp_wr_o,
  output logic [DATA_W-1:0]   wdata_o,
  input  logic [DATA_W-1:0]   ib_rdata_i,
  output logic                ib_rd_o,
  input  logic [DATA_W-1:0]   byp_rdata_i,
  output logic [4*OFF_W-1:0]  offsets_o,
  output logic                err_o
);
  localparam int NUM_OFF = 4;
  localparam int SEL_W   = $clog2(NUM_OFF);

  cmd_e             cmd;
  addr_kind_e       kind;
  logic             wr_refused;
  logic [OFF_W-1:0] off_rd;
  logic [DATA_W-1:0] in_q;
  logic             ob_wr_q, byp_wr_q, err_q;

  assign kind = addr_kind(addr_i);

  fpc_cmd_decode u_dec (
    .cs_ni     (cs_ni),
    .rw_i      (rw_i),
    .en_ni     (en_ni),
    .bus_drv_i (bus_oe_o),
    .cmd_o     (cmd),
    .wr_err_o  (wr_refused)
  );

  fpc_offset_bank #(
    .OFF_W   (OFF_W),
    .NUM     (NUM_OFF),
    .RST_VAL (OFF_RST)
  ) u_off (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (cmd == CMD_WRITE && kind == AK_OFF),
    .sel_i   (addr_i[SEL_W-1:0]),
    .wdata_i (bus_i[OFF_W-1:0]),
    .off_o   (offsets_o),
    .rd_o    (off_rd)
  );

  fpc_out_path #(
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cmd == CMD_READ && kind != AK_NONE),
    .kind_i  (kind),
    .fifo_i  (ib_rdata_i),
    .byp_i   (byp_rdata_i),
    .off_i   (off_rd),
    .cs_ni   (cs_ni),
    .oe_ni   (oe_ni),
    .rw_i    (rw_i),
    .data_o  (bus_o),
    .drive_o (bus_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q     <= '0;
      ob_wr_q  <= 1'b0;
      byp_wr_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (cmd == CMD_WRITE) in_q <= bus_i;
      ob_wr_q  <= cmd == CMD_WRITE && kind == AK_FIFO && !ob_full_i;
      byp_wr_q <= cmd == CMD_WRITE && kind == AK_BYP;
      err_q    <= wr_refused;
    end
  end

  assign wdata_o  = in_q;
  assign ob_wr_o  = ob_wr_q;
  assign byp_wr_o = byp_wr_q;
  assign err_o    = err_q;
  assign ib_rd_o  = cmd == CMD_READ && kind == AK_FIFO;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int DATA_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rw_i,
  input logic              en_ni,
  input logic [2:0]        addr_i,
  input logic [DATA_W-1:0] bus_o,
  input logic              bus_oe_o,
  input logic              ob_full_i,
  input logic              ob_wr_o,
  input logic              byp_wr_o,
  input logic [DATA_W-1:0] ib_rdata_i,
  input logic              ib_rd_o,
  input logic              err_o
);
  p_rd_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ib_rd_o |=> (bus_o == $past(ib_rdata_i)));

  p_wr_origin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ob_wr_o |-> $past(!cs_ni && !rw_i && !en_ni && addr_i == 3'b000 && !ob_full_i));

  p_no_push_full_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rw_i && !en_ni && addr_i == 3'b000 && ob_full_i) |=> !ob_wr_o);

  p_refused_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!ob_wr_o && !byp_wr_o));

  p_hiz_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rw_i |=> !bus_oe_o);

  p_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> ($stable(bus_o) && !ob_wr_o && !byp_wr_o));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && rw_i && en_ni) |=> $stable(bus_o));
endmodule

bind fifo_port_ctrl fpc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .rw_i       (rw_i),
  .en_ni      (en_ni),
  .addr_i     (addr_i),
  .bus_o      (bus_o),
  .bus_oe_o   (bus_oe_o),
  .ob_full_i  (ob_full_i),
  .ob_wr_o    (ob_wr_o),
  .byp_wr_o   (byp_wr_o),
  .ib_rdata_i (ib_rdata_i),
  .ib_rd_o    (ib_rd_o),
  .err_o      (err_o)
);

// File: tb/fifo_port_ctrl_tb.sv
`timescale 1ns/1ps
module fifo_port_ctrl_tb;
  localparam int DW = 18;
  localparam int OW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rw = 1'b0, en_n = 1'b1, oe_n = 1'b1, full = 1'b0;
  logic [2:0] addr = '0;
  logic [DW-1:0] din = '0, ib_data = '0, byp_data = '0;
  logic [DW-1:0] bus_o, wdata;
  logic bus_oe, ob_wr, byp_wr, ib_rd, err;
  logic [4*OW-1:0] offs;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] q_ob[$];
  logic [DW-1:0] q_byp[$];

  always #2.5 clk = ~clk;

  fifo_port_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rw_i(rw), .en_ni(en_n),
    .oe_ni(oe_n), .addr_i(addr), .bus_i(din), .bus_o(bus_o), .bus_oe_o(bus_oe),
    .ob_full_i(full), .ob_wr_o(ob_wr), .byp_wr_o(byp_wr), .wdata_o(wdata),
    .ib_rdata_i(ib_data), .ib_rd_o(ib_rd), .byp_rdata_i(byp_data),
    .offsets_o(offs), .err_o(err)
  );

  function automatic logic [OW-1:0] off_f(input int k);
    return offs[k*OW +: OW];
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic c, input logic r, input logic e, input logic o,
                    input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cs_n = c; rw = r; en_n = e; oe_n = o; addr = a; din = d;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // monitor: pops expected pushes as strobes appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (ob_wr) begin
        checks++;
        if (q_ob.size() == 0) begin
          errors++;
          $display("FAIL R3/R12 unexpected push actual=%0h expected=none", wdata);
        end else begin
          logic [DW-1:0] e;
          e = q_ob.pop_front();
          if (wdata !== e) begin
            errors++;
            $display("FAIL R3 push data actual=%0h expected=%0h", wdata, e);
          end
        end
      end
      if (byp_wr) begin
        checks++;
        if (q_byp.size() == 0) begin
          errors++;
          $display("FAIL R4 unexpected bypass actual=%0h expected=none", wdata);
        end else begin
          logic [DW-1:0] e;
          e = q_byp.pop_front();
          if (wdata !== e) begin
            errors++;
            $display("FAIL R4 bypass data actual=%0h expected=%0h", wdata, e);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 bus", bus_o, '0);
    chk("R1 oe", DW'(bus_oe), '0);
    for (int k = 0; k < 4; k++) chk("R1 offset", DW'(off_f(k)), 18'd8);
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk("R1 strobes", DW'({ob_wr, byp_wr, err}), '0);

    // R3 back-to-back FIFO writes
    q_ob.push_back(18'h2A5A5); op(0, 0, 0, 1, 3'b000, 18'h2A5A5); tick();
    q_ob.push_back(18'h15A5A); op(0, 0, 0, 1, 3'b000, 18'h15A5A); tick();
    // R4 bypass write
    q_byp.push_back(18'h3C3C3); op(0, 0, 0, 1, 3'b001, 18'h3C3C3); tick();
    // R5 offset writes
    op(0, 0, 0, 1, 3'b100, 18'd5); tick();
    op(0, 0, 0, 1, 3'b111, 18'd300); tick();
    chk("R5 ob_ae", DW'(off_f(0)), 18'd5);
    chk("R5 ib_af", DW'(off_f(3)), 18'd300);
    chk("R5 ob_af untouched", DW'(off_f(1)), 18'd8);

    // R6 FIFO read
    ib_data = 18'h01234;
    op(0, 1, 0, 0, 3'b000, '0); #1;
    chk("R6 pop strobe", DW'(ib_rd), 18'd1);
    chk("R10 no drive after write edge", DW'(bus_oe), '0);
    tick();
    chk("R6 read data", bus_o, 18'h01234);
    chk("R10 drive after read edge", DW'(bus_oe), 18'd1);

    // R7 bypass read
    byp_data = 18'h3FFF0;
    op(0, 1, 0, 0, 3'b001, '0); #1;
    chk("R7 no pop", DW'(ib_rd), '0);
    tick();
    chk("R7 read data", bus_o, 18'h3FFF0);

    // R8 offset reads
    op(0, 1, 0, 0, 3'b111, '0); tick();
    chk("R8 read ib_af", bus_o, 18'd300);
    op(0, 1, 0, 0, 3'b100, '0); tick();
    chk("R8 read ob_ae", bus_o, 18'd5);

    // R14 reserved read
    op(0, 1, 0, 0, 3'b010, '0); tick();
    chk("R14 reserved read", bus_o, 18'd5);

    // R9 hold
    ib_data = 18'h0BEEF;
    op(0, 1, 1, 0, 3'b000, '0); #1;
    chk("R9 no pop", DW'(ib_rd), '0);
    tick();
    chk("R9 hold", bus_o, 18'd5);

    // R11 write while driving
    op(0, 0, 0, 0, 3'b100, 18'd77); #1;
    chk("R11 driving before", DW'(bus_oe), 18'd1);
    tick();
    chk("R11 err", DW'(err), 18'd1);
    chk("R11 offset kept", DW'(off_f(0)), 18'd5);
    chk("R10 hiz despite oe", DW'(bus_oe), '0);

    // R2 disabled
    op(1, 0, 0, 0, 3'b101, 18'd123); #1;
    chk("R2 hiz", DW'(bus_oe), '0);
    tick();
    chk("R2 offset kept", DW'(off_f(1)), 18'd8);
    op(1, 1, 0, 0, 3'b000, '0); #1;
    chk("R2 no pop", DW'(ib_rd), '0);
    tick();
    chk("R2 bus kept", bus_o, 18'd5);
    chk("R2 hiz read", DW'(bus_oe), '0);

    // R12 full suppresses push
    full = 1'b1;
    op(0, 0, 0, 1, 3'b000, 18'h00111); tick();
    full = 1'b0;
    q_ob.push_back(18'h00222); op(0, 0, 0, 1, 3'b000, 18'h00222); tick();

    // R13 enable high write ignored
    op(0, 0, 1, 1, 3'b110, 18'd9); tick();
    chk("R13 offset kept", DW'(off_f(2)), 18'd8);

    // R14 reserved write
    op(0, 0, 0, 1, 3'b011, 18'h12345); tick();
    chk("R14 offsets kept", DW'(off_f(3)), 18'd300);

    op(1, 0, 1, 1, 3'b000, '0);
    repeat (3) tick();
    chk("R3 queue drained", DW'(q_ob.size()), '0);
    chk("R4 queue drained", DW'(q_byp.size()), '0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule